// File: doc/BRIEF.md
# Ping-Pong Character Row Buffer

This block is a two-half storage array placed between the logic that fetches a text row from display memory and the logic that turns character cells into pixels. One half, the fill side, receives the fully expanded 32-bit description of each character cell of the next text row. The other half, the display side, is read one column at a time at character rate, once per video line of the current row.

A pulse on the row-boundary input exchanges the roles of the two halves. The whole next row can therefore be written during one line-flyback interval while the row on screen is still being read. A status flag records, at each exchange, whether the half about to go on screen had every column written since the exchange before.

The fill port is a valid/ready stream. `fill_ready` is high in every cycle except one in which `row_swap` is high. A beat is taken only when `fill_valid` and `fill_ready` are both high, so an upstream source must hold its beat across a swap cycle. The display read port has no handshake: a column index goes in, and the entry comes out one clock later.

Top module: `pp_row_buffer`

## Requirements
- R1: While reset is held, `fill_short` and `rd_data` are 0 and `fill_ready` is 1. On leaving reset, half A is the fill side and half B is the display side.
- R2: `fill_ready` is 0 exactly in cycles where `row_swap` is 1. A beat offered while `fill_ready` is 0 is not stored and does not count toward fill completeness.
- R3: An accepted beat stores `fill_data` at column `fill_col` of the current fill half only. It is not visible on the display port until the next swap.
- R4: `rd_data` presents the display-half entry at `rd_col` in the clock cycle after `rd_col` is applied.
- R5: Every `row_swap` pulse exchanges the two halves. A half keeps its contents across swaps until it is written again while it is the fill side.
- R6: Fill writes to any column, including the column being read, never change the data returned by the display port during the same row.
- R7: At each swap, `fill_short` becomes 1 if fewer than COLS distinct columns (default 40) were accepted since the previous swap or reset, and becomes 0 otherwise. It holds its value between swaps.
- R8: Repeated accepted writes to one column count as a single column toward completeness. The last value written is the one stored.
- R9: A column index of COLS or above (40..63 by default) is out of range. A write to it is dropped and does not count toward completeness. A read of it returns 0.
- R10: A read applied in the same cycle as a swap returns data from the display half in effect before that swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_swap | input | 1 | Row-boundary pulse that exchanges the halves |
| fill_valid | input | 1 | Fill beat offered |
| fill_ready | output | 1 | Fill beat can be taken this cycle |
| fill_col | input | 6 | Fill column index |
| fill_data | input | 32 | Expanded character cell entry |
| rd_col | input | 6 | Display column index |
| rd_data | output | 32 | Display entry, one clock after `rd_col` |
| fill_short | output | 1 | Last swap exposed an incompletely filled half |

## Verification
A wrong role bit shows on the very next display read. The port returns either the entry just written on the fill side or a stale value from two rows back, so comparing every read against a model of both halves catches it within one cycle of the bad swap. A wrong completeness bitmap stays hidden until the next swap, when `fill_short` takes the wrong value. Full fills, fills with one column missing, fills with duplicate writes and fills with dropped out-of-range beats are all followed by a swap so that this error surfaces at that edge.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;
  localparam int unsigned DEF_COLS    = 40;
  localparam int unsigned DEF_ENTRY_W = 32;

  // Role encoding: which half currently receives fill writes.
  typedef enum logic {
    HALF_A = 1'b0,
    HALF_B = 1'b1
  } half_e;
endpackage

// File: rtl/rowbuf_bank.sv
module rowbuf_bank #(
  parameter int unsigned COLS    = 40,
  parameter int unsigned ENTRY_W = 32,
  parameter int unsigned COL_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [COL_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [COL_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);
  localparam logic [COL_W-1:0] LIMIT = COL_W'(COLS);

  logic [ENTRY_W-1:0] mem [COLS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdata <= '0;
    else if (raddr < LIMIT)  rdata <= mem[raddr];
    else                     rdata <= '0;
  end
endmodule

// File: rtl/rowbuf_role.sv
module rowbuf_role
  import rowbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  swap,
  output half_e fill_half
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fill_half <= HALF_A;
    else if (swap) fill_half <= (fill_half == HALF_A) ? HALF_B : HALF_A;
  end
endmodule

// File: rtl/rowbuf_tracker.sv
module rowbuf_tracker #(
  parameter int unsigned COLS  = 40,
  parameter int unsigned COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_accept,
  input  logic [COL_W-1:0] wr_col,
  input  logic             swap,
  output logic             short_o
);
  logic [COLS-1:0] seen;
  logic [COLS-1:0] hit;

  for (genvar i = 0; i < COLS; i++) begin : g_hit
    assign hit[i] = wr_accept && (wr_col == COL_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= '0;
      short_o <= 1'b0;
    end else if (swap) begin
      short_o <= ~&seen;
      seen    <= '0;
    end else begin
      seen <= seen | hit;
    end
  end
endmodule

// File: rtl/pp_row_buffer.sv
module pp_row_buffer
  import rowbuf_pkg::*;
#(
  parameter int unsigned COLS    = DEF_COLS,
  parameter int unsigned ENTRY_W = DEF_ENTRY_W,
  localparam int unsigned COL_W  = $clog2(COLS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               row_swap,
  input  logic               fill_valid,
  output logic               fill_ready,
  input  logic [COL_W-1:0]   fill_col,
  input  logic [ENTRY_W-1:0] fill_data,
  input  logic [COL_W-1:0]   rd_col,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               fill_short
);
  localparam logic [COL_W-1:0] LIMIT = COL_W'(COLS);

  half_e              fill_sel;
  logic               col_ok;
  logic               wr_accept;
  logic [1:0]         bank_we;
  logic [ENTRY_W-1:0] bank_q [2];
  logic               disp_sel_q;

  // A swap cycle refuses beats so that a write never lands on a half
  // whose role is changing at that edge.
  assign fill_ready = ~row_swap;
  assign col_ok     = fill_col < LIMIT;
  assign wr_accept  = fill_valid && fill_ready && col_ok;
  assign bank_we[0] = wr_accept && (fill_sel == HALF_A);
  assign bank_we[1] = wr_accept && (fill_sel == HALF_B);

  rowbuf_role u_role (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap      (row_swap),
    .fill_half (fill_sel)
  );

  rowbuf_tracker #(.COLS(COLS), .COL_W(COL_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_accept (wr_accept),
    .wr_col    (fill_col),
    .swap      (row_swap),
    .short_o   (fill_short)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    rowbuf_bank #(.COLS(COLS), .ENTRY_W(ENTRY_W), .COL_W(COL_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we[b]),
      .waddr (fill_col),
      .wdata (fill_data),
      .raddr (rd_col),
      .rdata (bank_q[b])
    );
  end

  // Display half as seen at the read edge, so the output mux lines up
  // with the registered bank outputs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disp_sel_q <= 1'b1;
    else        disp_sel_q <= (fill_sel == HALF_A);
  end

  assign rd_data = bank_q[disp_sel_q];
endmodule

// File: rtl/rowbuf_chk.sv
module rowbuf_chk
  import rowbuf_pkg::*;
#(
  parameter int unsigned COLS  = 40,
  parameter int unsigned COL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_swap,
  input logic             fill_valid,
  input logic [COL_W-1:0] fill_col,
  input logic             fill_short,
  input logic [1:0]       bank_we,
  input half_e            fill_sel
);
  // R2
  swap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_swap |-> (bank_we == 2'b00));

  // R3
  disp_half_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we[(fill_sel == HALF_A) ? 1 : 0]);

  // R3
  single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_we) <= 1);

  // R5
  role_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_swap |=> (fill_sel != $past(fill_sel)));

  // R5
  role_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_swap |=> $stable(fill_sel));

  // R7
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_swap |=> $stable(fill_short));

  // R9
  range_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (fill_col >= COL_W'(COLS))) |-> (bank_we == 2'b00));
endmodule

bind pp_row_buffer rowbuf_chk #(.COLS(COLS), .COL_W(COL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .row_swap   (row_swap),
  .fill_valid (fill_valid),
  .fill_col   (fill_col),
  .fill_short (fill_short),
  .bank_we    (bank_we),
  .fill_sel   (fill_sel)
);

// File: tb/pp_row_buffer_tb_top.sv
`timescale 1ns/1ps
module pp_row_buffer_tb_top;
  localparam int COLS = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        row_swap = 1'b0;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [5:0]  fill_col = '0;
  logic [31:0] fill_data = '0;
  logic [5:0]  rd_col = '0;
  logic [31:0] rd_data;
  logic        fill_short;

  int checks = 0;
  int fails  = 0;

  // Bench model
  logic [31:0]     m_mem   [2][COLS];
  bit              m_known [2][COLS];
  int              m_fill  = 0;
  logic [COLS-1:0] m_seen  = '0;
  bit              m_short = 0;

  always #5 clk = ~clk;

  pp_row_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .row_swap(row_swap),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_col(fill_col), .fill_data(fill_data),
    .rd_col(rd_col), .rd_data(rd_data), .fill_short(fill_short)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected read value and whether it is defined.
  function automatic bit exp_known(int rc);
    if (rc >= COLS) return 1;
    return m_known[1 - m_fill][rc];
  endfunction

  function automatic logic [31:0] exp_read(int rc);
    if (rc >= COLS) return 32'h0;
    return m_mem[1 - m_fill][rc];
  endfunction

  // One clock: inputs driven at the falling edge, outputs checked at the next.
  task automatic step(bit sw, bit v, int c, logic [31:0] d, int rc, string tag);
    bit          kn;
    logic [31:0] ex;
    row_swap   = sw;
    fill_valid = v;
    fill_col   = 6'(c);
    fill_data  = d;
    rd_col     = 6'(rc);
    #1;
    chk({tag, " R2 ready"}, {31'b0, fill_ready}, {31'b0, ~sw});
    kn = exp_known(rc);
    ex = exp_read(rc);
    @(posedge clk);
    if (sw) begin
      m_short = ~&m_seen;
      m_seen  = '0;
      m_fill  = 1 - m_fill;
    end else if (v && c < COLS) begin
      m_mem[m_fill][c]   = d;
      m_known[m_fill][c] = 1;
      m_seen[c]          = 1'b1;
    end
    @(negedge clk);
    if (kn) chk({tag, " R4 read"}, rd_data, ex);
    chk({tag, " R7 short"}, {31'b0, fill_short}, {31'b0, m_short});
  endtask

  task automatic fill_row(bit full, int skip);
    for (int c = 0; c < COLS; c++) begin
      if (full || c != skip)
        step(0, 1, c, $urandom, $urandom_range(0, 47), "fill");
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int h = 0; h < 2; h++)
      for (int c = 0; c < COLS; c++) m_known[h][c] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 short", {31'b0, fill_short}, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 ready", {31'b0, fill_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: write into half A, not visible before the swap
    step(0, 1, 5, 32'hAAAA_0005, 5, "R3");
    step(0, 0, 0, 0, 5, "R3");
    // R7: partial fill then swap raises the flag
    step(1, 0, 0, 0, 5, "R7");
    chk("R7 partial", {31'b0, fill_short}, 32'h1);
    // R3/R4: now visible
    step(0, 0, 0, 0, 5, "R3");
    chk("R3 visible", rd_data, 32'hAAAA_0005);

    // R6: write same column on fill side, display unaffected
    step(0, 1, 5, 32'hBBBB_0005, 5, "R6");
    step(0, 0, 0, 0, 5, "R6");
    chk("R6 display", rd_data, 32'hAAAA_0005);

    // R2: beat during swap is dropped; R10: read in swap cycle is old half
    step(1, 1, 5, 32'hDEAD_BEEF, 5, "R10");
    chk("R10 pre-swap", rd_data, 32'hAAAA_0005);
    step(0, 0, 0, 0, 5, "R5");
    chk("R5 swapped", rd_data, 32'hBBBB_0005);
    // R5: third swap brings back half A contents (untouched since)
    step(1, 0, 0, 0, 5, "R5");
    step(0, 0, 0, 0, 5, "R2");
    chk("R2 dropped", rd_data, 32'hAAAA_0005);

    // R7: full fill clears the flag
    fill_row(1, 0);
    step(1, 0, 0, 0, 0, "R7");
    chk("R7 full", {31'b0, fill_short}, 32'h0);

    // R8: duplicates do not complete a fill; last value wins
    fill_row(0, 17);
    step(0, 1, 3, 32'h1111_1111, 0, "R8");
    step(0, 1, 3, 32'h2222_2222, 0, "R8");
    // R9: out-of-range write does not count
    step(0, 1, 45, 32'h3333_3333, 45, "R9");
    chk("R9 read oob", rd_data, 32'h0);
    step(1, 0, 0, 0, 0, "R8");
    chk("R8 dup not full", {31'b0, fill_short}, 32'h1);
    step(0, 0, 0, 0, 3, "R8");
    chk("R8 last wins", rd_data, 32'h2222_2222);
    step(0, 0, 0, 0, 63, "R9");
    chk("R9 read 63", rd_data, 32'h0);

    // Random rows
    for (int row = 0; row < 40; row++) begin
      int mode = $urandom_range(0, 2);
      if (mode == 0) fill_row(1, 0);
      else if (mode == 1) fill_row(0, $urandom_range(0, COLS - 1));
      else begin
        for (int k = 0; k < 60; k++)
          step(0, $urandom_range(0, 9) != 0, $urandom_range(0, 47), $urandom,
               $urandom_range(0, 47), "rand");
      end
      step(1, $urandom_range(0, 1), $urandom_range(0, 47), $urandom,
           $urandom_range(0, 47), "rand-swap");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule